// File: doc/BRIEF.md
# Four-Port Byte Routing Multiplexer

This block steers data from four byte-wide lanes (lanes 0 to 3, each 9 bits wide) onto two 9-bit output buses, X and Y. Each lane owns a capture register that samples that lane's input bus on a rising clock edge when the lane's load enable is high. The capture register keeps its value when the enable is low.

Routing happens in two combinational stages. The first stage applies one 2-bit source code to all four lanes at once. The code gives each lane a node value taken from one of four sources: the live lane input, the lane's capture register, the lane's slice of a readback bus supplied by the opposite-direction block, or a forced zero used for diagnostics. The second stage picks which node drives X and which drives Y.

The block can be used as a 4:1 byte multiplexer on X alone. It can also be used as a 2:1 multiplexer of an 18-bit word, with lane 0 or 2 on X and lane 1 or 3 on Y. Lane inputs are sampled at all times. A value that a lane is driving outward can therefore be looped back and captured.

Top module: `byte_route_mux`

## Requirements
- R1: A synchronous reset, sampled on the rising clock edge with `rst` high, clears all four capture registers to zero.
- R2: On a rising edge with `rst` low and `load_en[k]` high, capture register k takes `lane_in[k*9 +: 9]`. The new value is visible on the outputs once that edge has passed.
- R3: On a rising edge with `load_en[k]` low, capture register k keeps its previous value, whatever `lane_in` carries.
- R4: With `src_sel` = 2'b00, each node equals its live lane input, so a value driven onto `lane_in` reaches X and Y without a clock edge.
- R5: With `src_sel` = 2'b01, each node equals its lane's capture register.
- R6: With `src_sel` = 2'b10, node k equals `rdbk_in[k*9 +: 9]`, the readback slice for lane k.
- R7: With `src_sel` = 2'b11, all four nodes are zero, so X and Y are both zero for every `x_sel` and `y_sel`.
- R8: `x_out` carries node `x_sel`: code 0 gives lane 0, 1 gives lane 1, 2 gives lane 2 and 3 gives lane 3.
- R9: `y_out` carries lane 1 when `y_sel` is 0 and lane 3 when `y_sel` is 1.
- R10: X and Y are selected independently in the same cycle. X can carry lane 0 or 2 while Y carries lane 1 or 3, which forms one 18-bit word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the capture registers |
| rst | input | 1 | Synchronous reset, active high |
| lane_in | input | 36 | Four lane input buses; lane k occupies bits k*9+8 down to k*9 |
| rdbk_in | input | 36 | Readback bus from the opposite-direction registers, using the same lane layout |
| load_en | input | 4 | Per-lane capture enable, active high |
| src_sel | input | 2 | First-stage source code: 00 live, 01 capture register, 10 readback, 11 zero |
| x_sel | input | 2 | Lane driven onto X |
| y_sel | input | 1 | 0 selects lane 1 onto Y, 1 selects lane 3 |
| x_out | output | 9 | X output byte |
| y_out | output | 9 | Y output byte |

## Verification
The bench builds the block with its default parameters: 9-bit lanes and four lanes. With these values every code of both select stages can be reached, along with the full 36-bit zero force and both halves of the 18-bit pairing. Since both select stages are combinational, a 2-bit X code and a 1-bit Y code are enough for random stimulus to cover all source, lane and Y-pairing combinations many times over. Load enables that are partly set leave some registers holding while their lanes change, which exercises both capture and hold.

// File: rtl/brm_pkg.sv
`timescale 1ns/1ps
package brm_pkg;

    // First-stage source codes, shared by every lane node
    typedef enum logic [1:0] {
        SRC_LIVE     = 2'b00,
        SRC_CAPTURE  = 2'b01,
        SRC_READBACK = 2'b10,
        SRC_ZERO     = 2'b11
    } src_sel_e;

endpackage

// File: rtl/brm_in_regs.sv
`timescale 1ns/1ps
module brm_in_regs #(
    parameter int LANE_W    = 9,
    parameter int NUM_LANES = 4,
    localparam int BUS_W    = LANE_W * NUM_LANES
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [BUS_W-1:0]     lane_in,
    input  logic [NUM_LANES-1:0] load_en,
    output logic [BUS_W-1:0]     cap_q
);

    typedef struct packed {
        logic [BUS_W-1:0] lanes;
    } cap_state_t;

    cap_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.lanes = '0;
        end else begin
            for (int k = 0; k < NUM_LANES; k++) begin
                if (load_en[k]) begin
                    st_d.lanes[k*LANE_W +: LANE_W] = lane_in[k*LANE_W +: LANE_W];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign cap_q = st_q.lanes;

endmodule

// File: rtl/brm_node_sel.sv
`timescale 1ns/1ps
module brm_node_sel #(
    parameter int LANE_W    = 9,
    parameter int NUM_LANES = 4,
    localparam int BUS_W    = LANE_W * NUM_LANES
) (
    input  logic [BUS_W-1:0] lane_in,
    input  logic [BUS_W-1:0] cap_q,
    input  logic [BUS_W-1:0] rdbk_in,
    input  logic [1:0]       src_sel,
    output logic [BUS_W-1:0] nodes
);
    import brm_pkg::*;

    src_sel_e src_code;
    assign src_code = src_sel_e'(src_sel);

    for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
        logic [LANE_W-1:0] pick_d;

        always_comb begin
            case (src_code)
                SRC_LIVE:     pick_d = lane_in[k*LANE_W +: LANE_W];
                SRC_CAPTURE:  pick_d = cap_q[k*LANE_W +: LANE_W];
                SRC_READBACK: pick_d = rdbk_in[k*LANE_W +: LANE_W];
                default:      pick_d = '0;
            endcase
        end

        assign nodes[k*LANE_W +: LANE_W] = pick_d;
    end

endmodule

// File: rtl/brm_port_sel.sv
`timescale 1ns/1ps
module brm_port_sel #(
    parameter int LANE_W    = 9,
    parameter int NUM_LANES = 4,
    localparam int BUS_W    = LANE_W * NUM_LANES,
    localparam int XSEL_W   = $clog2(NUM_LANES),
    localparam int YSEL_W   = $clog2(NUM_LANES / 2)
) (
    input  logic [BUS_W-1:0]  nodes,
    input  logic [XSEL_W-1:0] x_sel,
    input  logic [YSEL_W-1:0] y_sel,
    output logic [LANE_W-1:0] x_out,
    output logic [LANE_W-1:0] y_out
);

    // Y draws only from odd lanes: code j selects lane 2*j+1
    logic [XSEL_W-1:0] y_lane;

    always_comb begin
        y_lane = XSEL_W'((int'(y_sel) * 2) + 1);
        x_out  = nodes[int'(x_sel)*LANE_W +: LANE_W];
        y_out  = nodes[int'(y_lane)*LANE_W +: LANE_W];
    end

endmodule

// File: rtl/byte_route_mux.sv
`timescale 1ns/1ps
module byte_route_mux #(
    parameter int LANE_W    = 9,
    parameter int NUM_LANES = 4,
    localparam int BUS_W    = LANE_W * NUM_LANES,
    localparam int XSEL_W   = $clog2(NUM_LANES),
    localparam int YSEL_W   = $clog2(NUM_LANES / 2)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [BUS_W-1:0]     lane_in,
    input  logic [BUS_W-1:0]     rdbk_in,
    input  logic [NUM_LANES-1:0] load_en,
    input  logic [1:0]           src_sel,
    input  logic [XSEL_W-1:0]    x_sel,
    input  logic [YSEL_W-1:0]    y_sel,
    output logic [LANE_W-1:0]    x_out,
    output logic [LANE_W-1:0]    y_out
);

    logic [BUS_W-1:0] cap_q;
    logic [BUS_W-1:0] nodes;

    brm_in_regs #(.LANE_W(LANE_W), .NUM_LANES(NUM_LANES)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .lane_in (lane_in),
        .load_en (load_en),
        .cap_q   (cap_q)
    );

    brm_node_sel #(.LANE_W(LANE_W), .NUM_LANES(NUM_LANES)) u_nodes (
        .lane_in (lane_in),
        .cap_q   (cap_q),
        .rdbk_in (rdbk_in),
        .src_sel (src_sel),
        .nodes   (nodes)
    );

    brm_port_sel #(.LANE_W(LANE_W), .NUM_LANES(NUM_LANES)) u_ports (
        .nodes (nodes),
        .x_sel (x_sel),
        .y_sel (y_sel),
        .x_out (x_out),
        .y_out (y_out)
    );

endmodule

// File: rtl/brm_checker.sv
`timescale 1ns/1ps
module brm_checker #(
    parameter int LANE_W    = 9,
    parameter int NUM_LANES = 4,
    localparam int BUS_W    = LANE_W * NUM_LANES,
    localparam int XSEL_W   = $clog2(NUM_LANES),
    localparam int YSEL_W   = $clog2(NUM_LANES / 2)
) (
    input logic                 clk,
    input logic                 rst,
    input logic [BUS_W-1:0]     lane_in,
    input logic [BUS_W-1:0]     rdbk_in,
    input logic [NUM_LANES-1:0] load_en,
    input logic [1:0]           src_sel,
    input logic [XSEL_W-1:0]    x_sel,
    input logic [YSEL_W-1:0]    y_sel,
    input logic [LANE_W-1:0]    x_out,
    input logic [LANE_W-1:0]    y_out
);
    import brm_pkg::*;

    function automatic logic [LANE_W-1:0] lane_of(logic [BUS_W-1:0] v, int i);
        return v[i*LANE_W +: LANE_W];
    endfunction

    // R4, R8: live source reaches X by x_sel
    assert_live_x_R4: assert property (@(posedge clk) disable iff (rst)
        (src_sel == SRC_LIVE) |-> (x_out == lane_of(lane_in, int'(x_sel))));

    // R6, R9: readback source reaches Y from the odd lane picked by y_sel
    assert_rdbk_y_R9: assert property (@(posedge clk) disable iff (rst)
        (src_sel == SRC_READBACK) |-> (y_out == lane_of(rdbk_in, int'(y_sel)*2 + 1)));

    // R6: readback source reaches X
    assert_rdbk_x_R6: assert property (@(posedge clk) disable iff (rst)
        (src_sel == SRC_READBACK) |-> (x_out == lane_of(rdbk_in, int'(x_sel))));

    // R7: forced zero on both outputs
    assert_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (src_sel == SRC_ZERO) |-> (x_out == '0 && y_out == '0));

    // R2: a lane loaded on the previous edge shows the captured value
    assert_load_R2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && src_sel == SRC_CAPTURE && $stable(x_sel) && $past(load_en[x_sel]))
        |-> (x_out == $past(lane_of(lane_in, int'(x_sel)))));

    // R3: a lane not loaded keeps its captured value
    assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && src_sel == SRC_CAPTURE && $past(src_sel) == SRC_CAPTURE
         && $stable(x_sel) && !$past(load_en[x_sel]))
        |-> $stable(x_out));

    // R1: the cycle after reset, every capture register reads zero
    assert_reset_R1: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && src_sel == SRC_CAPTURE) |-> (x_out == '0 && y_out == '0));

endmodule

bind byte_route_mux brm_checker #(.LANE_W(LANE_W), .NUM_LANES(NUM_LANES)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .lane_in (lane_in),
    .rdbk_in (rdbk_in),
    .load_en (load_en),
    .src_sel (src_sel),
    .x_sel   (x_sel),
    .y_sel   (y_sel),
    .x_out   (x_out),
    .y_out   (y_out)
);

// File: tb/sim_byte_route_mux.sv
`timescale 1ns/1ps
module sim_byte_route_mux;

    logic        clk = 1'b0;
    logic        rst;
    logic [35:0] lane_in;
    logic [35:0] rdbk_in;
    logic [3:0]  load_en;
    logic [1:0]  src_sel;
    logic [1:0]  x_sel;
    logic        y_sel;
    logic [8:0]  x_out;
    logic [8:0]  y_out;

    int total = 0;
    int failed = 0;
    logic [8:0] cap_m [4];

    always #2 clk = ~clk;

    byte_route_mux u0 (
        .clk(clk), .rst(rst), .lane_in(lane_in), .rdbk_in(rdbk_in),
        .load_en(load_en), .src_sel(src_sel), .x_sel(x_sel), .y_sel(y_sel),
        .x_out(x_out), .y_out(y_out)
    );

    function automatic logic [8:0] exp_node(logic [1:0] s, int k);
        case (s)
            2'b00:   return lane_in[k*9 +: 9];
            2'b01:   return cap_m[k];
            2'b10:   return rdbk_in[k*9 +: 9];
            default: return 9'h000;
        endcase
    endfunction

    task automatic chk(string req, logic [8:0] act, logic [8:0] exp);
        total++;
        if (act !== exp) begin
            failed++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_both(string req);
        #1;
        chk({req, " x"}, x_out, exp_node(src_sel, int'(x_sel)));
        chk({req, " y"}, y_out, exp_node(src_sel, int'(y_sel) * 2 + 1));
    endtask

    // one rising edge, model update, then back to the falling edge
    task automatic tick();
        @(posedge clk);
        for (int k = 0; k < 4; k++) begin
            if (rst) cap_m[k] = 9'h000;
            else if (load_en[k]) cap_m[k] = lane_in[k*9 +: 9];
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        failed++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        for (int k = 0; k < 4; k++) cap_m[k] = 9'h1FF;
        rst = 1'b1; lane_in = '1; rdbk_in = '0; load_en = 4'hF;
        src_sel = 2'b00; x_sel = 2'd0; y_sel = 1'b0;
        @(negedge clk);
        tick();
        tick();
        rst = 1'b0; load_en = 4'h0;

        // R1: every capture register reads zero after reset
        src_sel = 2'b01;
        for (int s = 0; s < 4; s++) begin
            x_sel = s[1:0];
            #1 chk("R1 reset x", x_out, 9'h000);
        end
        y_sel = 1'b1;
        #1 chk("R1 reset y", y_out, 9'h000);

        // R2, R5: load all lanes, read back through capture source
        lane_in = {9'h1A5, 9'h0F3, 9'h155, 9'h0AA};
        load_en = 4'hF;
        #1 chk("R2 not before edge", x_out, 9'h000);
        tick();
        load_en = 4'h0;
        lane_in = '0;
        x_sel = 2'd0; #1 chk("R2 lane0", x_out, 9'h0AA);
        x_sel = 2'd3; #1 chk("R5 lane3", x_out, 9'h1A5);

        // R3: only lanes 0 and 2 load; 1 and 3 hold
        lane_in = {9'h011, 9'h022, 9'h033, 9'h044};
        load_en = 4'b0101;
        tick();
        load_en = 4'h0;
        x_sel = 2'd0; #1 chk("R2 partial lane0", x_out, 9'h044);
        x_sel = 2'd1; #1 chk("R3 hold lane1", x_out, 9'h155);
        x_sel = 2'd2; #1 chk("R2 partial lane2", x_out, 9'h022);
        x_sel = 2'd3; #1 chk("R3 hold lane3", x_out, 9'h1A5);

        // R4, R8: live data on every X code
        src_sel = 2'b00;
        lane_in = {9'h1C3, 9'h0B2, 9'h0A1, 9'h190};
        for (int s = 0; s < 4; s++) begin
            x_sel = s[1:0];
            #1 chk("R8 live x lane", x_out, lane_in[s*9 +: 9]);
        end
        lane_in[8:0] = 9'h17E; x_sel = 2'd0;
        #1 chk("R4 live follows without edge", x_out, 9'h17E);

        // R9: both Y codes
        y_sel = 1'b0; #1 chk("R9 y lane1", y_out, 9'h0A1);
        y_sel = 1'b1; #1 chk("R9 y lane3", y_out, 9'h1C3);

        // R6: readback
        src_sel = 2'b10;
        rdbk_in = {9'h101, 9'h0FE, 9'h123, 9'h1DC};
        x_sel = 2'd2; #1 chk("R6 readback lane2", x_out, 9'h0FE);
        y_sel = 1'b0; #1 chk("R6 readback y lane1", y_out, 9'h123);

        // R7: zero force for every select
        src_sel = 2'b11; lane_in = '1; rdbk_in = '1;
        for (int s = 0; s < 4; s++) begin
            x_sel = s[1:0]; y_sel = s[0];
            #1 chk("R7 zero x", x_out, 9'h000);
            chk("R7 zero y", y_out, 9'h000);
        end

        // R10: 18-bit word, X lane 2 with Y lane 3 at once
        src_sel = 2'b00;
        lane_in = {9'h1E1, 9'h0D2, 9'h0C3, 9'h1B4};
        x_sel = 2'd2; y_sel = 1'b1;
        #1 chk("R10 pair x", x_out, 9'h0D2);
        chk("R10 pair y", y_out, 9'h1E1);
        x_sel = 2'd0; y_sel = 1'b0;
        #1 chk("R10 pair x low", x_out, 9'h1B4);
        chk("R10 pair y low", y_out, 9'h0C3);

        // random mix over all codes, checked before and after each edge
        for (int i = 0; i < 400; i++) begin
            lane_in = {$urandom, $urandom};
            rdbk_in = {$urandom, $urandom};
            load_en = 4'($urandom);
            src_sel = 2'($urandom);
            x_sel   = 2'($urandom);
            y_sel   = 1'($urandom);
            check_both("R5 random pre-edge");
            tick();
            check_both("R2 random post-edge");
        end

        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

endmodule